// File: doc/BRIEF.md
# Per-Context Descriptor Register Front End

This block sits between a register access port and the receive and transmit engines of a shared network device. It gives each of several software contexts a private set of four descriptor registers: receive descriptor, receive status, transmit descriptor and transmit status. An access address is split in two: the bits above the low byte select the context, and the low byte selects the register.

Writing a descriptor stores it, marks that context busy, and places the context number in a request queue for the matching engine. The engine takes requests from the queue through a valid/ready port. When an engine finishes a request, it returns a completion word through a completion port. The completion word becomes the context's new status and clears its busy flag. Reads of a status register combine the stored status with live FIFO levels, so software can poll without a separate status access.

Register offsets: receive descriptor 0x00, receive status 0x08, receive status mirror 0x10, transmit descriptor 0x18, transmit status 0x20, transmit status mirror 0x28. Every access gets a response one cycle later on `rsp_valid`. A rejected access returns `rsp_err`=1, returns data 0, and changes nothing.

Top module: `vctx_reg_front`

## Requirements
- R1: The context index is `acc_addr` shifted right by 8, and the register offset is `acc_addr[7:0]`. An index of NCTX or above gives an error response and changes no register and no queue.
- R2: A receive descriptor write (offset 0x00) to a context whose status bit 31 (busy) is clear is accepted. It stores the written value, sets that context's receive status to exactly 0x0000_0000_8000_0000, and appends the index to the receive queue.
- R3: A receive descriptor write to a context whose receive status bit 31 is set gets an error response. The stored descriptor, the status and the queue stay unchanged.
- R4: `rx_kick` pulses together with the response of an accepted receive descriptor write only if `rx_en` and `rx_idle` were both 1 in the write cycle. `tx_kick` follows the same rule for transmit with `tx_en` and `tx_idle`.
- R5: A transmit descriptor write (offset 0x18) to a context whose transmit status bit 31 is clear stores the value and sets the status to bit 31 only. It appends the index to the transmit queue unless the queue is non-empty, its head equals that index, and the head is not being popped in the same cycle.
- R6: A read at offset 0x08 or 0x10 returns the stored receive status with bits [47:32] replaced by `rx_fifo_pkts`.
- R7: A read at offset 0x20 or 0x28 returns the stored transmit status with the following changes:
  - bits [47:32] are replaced by `tx_fifo_pkts`;
  - bit 29 is set to (`tx_fifo_free` < `tx_max_copy`);
  - bit 28 is set to (`tx_fifo_used` < `tx_mark`).
- R8: A completion pulse loads the completion word, with bit 31 forced to 0, into the addressed context's status. This applies to the receive port (`rx_cmpl_*`) and the transmit port (`tx_cmpl_*`). After the completion, a new descriptor write to that context is accepted.
- R9: Each request queue holds NCTX entries and returns them in write order. An entry pops when valid and ready are both 1. A write that would push into a full queue gets an error response and changes nothing. The full and empty flags follow the queue occupancy.
- R10: After reset, all context registers read 0, both queues are empty with valid low, and no response or kick is pending.
- R11: A read of a descriptor offset returns the stored descriptor. An access to any offset not listed above gets an error response. A write to a status offset also gets an error response. In both cases nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Context index and register offset |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data, 0 on writes and errors |
| rx_en | input | 1 | Receive enabled |
| rx_idle | input | 1 | Receive engine idle |
| tx_en | input | 1 | Transmit enabled |
| tx_idle | input | 1 | Transmit engine idle |
| rx_kick | output | 1 | Start pulse to the receive engine |
| tx_kick | output | 1 | Start pulse to the transmit engine |
| rx_cmpl_valid | input | 1 | Receive completion strobe |
| rx_cmpl_ctx | input | CW | Completed receive context |
| rx_cmpl_word | input | 64 | New receive status |
| tx_cmpl_valid | input | 1 | Transmit completion strobe |
| tx_cmpl_ctx | input | CW | Completed transmit context |
| tx_cmpl_word | input | 64 | New transmit status |
| rx_fifo_pkts | input | 16 | Packets in the receive FIFO |
| tx_fifo_pkts | input | 16 | Packets in the transmit FIFO |
| tx_fifo_free | input | LW | Free transmit FIFO space |
| tx_fifo_used | input | LW | Transmit FIFO occupancy |
| tx_max_copy | input | LW | Largest single transmit copy |
| tx_mark | input | LW | Transmit low watermark |
| rxq_valid | output | 1 | Receive queue head valid |
| rxq_ready | input | 1 | Receive engine takes the head |
| rxq_ctx | output | CW | Receive queue head context |
| rxq_full | output | 1 | Receive queue full |
| rxq_empty | output | 1 | Receive queue empty |
| txq_valid | output | 1 | Transmit queue head valid |
| txq_ready | input | 1 | Transmit engine takes the head |
| txq_ctx | output | CW | Transmit queue head context |
| txq_full | output | 1 | Transmit queue full |
| txq_empty | output | 1 | Transmit queue empty |

## Verification
The assertions assume the engines obey the queue handshake: once `rxq_valid` or `txq_valid` is high, the head stays put until ready is seen. The assertions also assume a completion names a context that the same engine has taken from its queue. The stimulus never raises ready and issues a same-context descriptor write in the same cycle. It sends completions only to contexts with an outstanding request. It holds ready low for several cycles before each pop, to exercise back-pressure.

// File: rtl/vctx_pkg.sv
package vctx_pkg;
  localparam int DW       = 64;
  localparam int BUSY_BIT = 31;
  localparam int FULL_BIT = 29;
  localparam int LOW_BIT  = 28;
  localparam int PKT_LSB  = 32;
  localparam int PKT_W    = 16;

  localparam logic [7:0] OFS_RX_DESC = 8'h00;
  localparam logic [7:0] OFS_RX_STAT = 8'h08;
  localparam logic [7:0] OFS_RX_POLL = 8'h10;
  localparam logic [7:0] OFS_TX_DESC = 8'h18;
  localparam logic [7:0] OFS_TX_STAT = 8'h20;
  localparam logic [7:0] OFS_TX_POLL = 8'h28;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_RX_DESC,
    KIND_RX_STAT,
    KIND_TX_DESC,
    KIND_TX_STAT
  } reg_kind_e;
endpackage

// File: rtl/vctx_addr_dec.sv
module vctx_addr_dec
  import vctx_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NCTX = 4,
  parameter int CW   = 2
) (
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] ctx_idx,
  output logic          idx_ok,
  output reg_kind_e     kind
);
  localparam int HW = AW - 8;

  logic [HW-1:0] hi;
  logic [7:0]    ofs;

  assign hi      = addr[AW-1:8];
  assign ofs     = addr[7:0];
  assign idx_ok  = hi < HW'(NCTX);
  assign ctx_idx = CW'(hi);

  always_comb begin
    case (ofs)
      OFS_RX_DESC: kind = KIND_RX_DESC;
      OFS_RX_STAT,
      OFS_RX_POLL: kind = KIND_RX_STAT;
      OFS_TX_DESC: kind = KIND_TX_DESC;
      OFS_TX_STAT,
      OFS_TX_POLL: kind = KIND_TX_STAT;
      default:     kind = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/vctx_ctx_bank.sv
module vctx_ctx_bank
  import vctx_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_we,
  input  logic          txd_we,
  input  logic [CW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic          rx_cmpl_valid,
  input  logic [CW-1:0] rx_cmpl_idx,
  input  logic [DW-1:0] rx_cmpl_word,
  input  logic          tx_cmpl_valid,
  input  logic [CW-1:0] tx_cmpl_idx,
  input  logic [DW-1:0] tx_cmpl_word,
  input  logic [CW-1:0] rd_idx,
  output logic [DW-1:0] rd_rx_desc,
  output logic [DW-1:0] rd_rx_done,
  output logic [DW-1:0] rd_tx_desc,
  output logic [DW-1:0] rd_tx_done
);
  localparam logic [DW-1:0] BUSY_ONLY = DW'(1) << BUSY_BIT;
  localparam logic [DW-1:0] BUSY_CLR  = ~BUSY_ONLY;

  logic [DW-1:0] rxd_all [NCTX];
  logic [DW-1:0] rxs_all [NCTX];
  logic [DW-1:0] txd_all [NCTX];
  logic [DW-1:0] txs_all [NCTX];

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic [DW-1:0] rxd_q, rxs_q, txd_q, txs_q;
    logic          hit_wr, hit_rxc, hit_txc;

    assign hit_wr  = wr_idx == CW'(i);
    assign hit_rxc = rx_cmpl_valid && (rx_cmpl_idx == CW'(i));
    assign hit_txc = tx_cmpl_valid && (tx_cmpl_idx == CW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rxd_q <= '0;
        rxs_q <= '0;
        txd_q <= '0;
        txs_q <= '0;
      end else begin
        if (rxd_we && hit_wr) begin
          rxd_q <= wdata;
          rxs_q <= BUSY_ONLY;
        end else if (hit_rxc) begin
          rxs_q <= rx_cmpl_word & BUSY_CLR;
        end
        if (txd_we && hit_wr) begin
          txd_q <= wdata;
          txs_q <= BUSY_ONLY;
        end else if (hit_txc) begin
          txs_q <= tx_cmpl_word & BUSY_CLR;
        end
      end
    end

    assign rxd_all[i] = rxd_q;
    assign rxs_all[i] = rxs_q;
    assign txd_all[i] = txd_q;
    assign txs_all[i] = txs_q;
  end

  always_comb begin
    rd_rx_desc = '0;
    rd_rx_done = '0;
    rd_tx_desc = '0;
    rd_tx_done = '0;
    for (int k = 0; k < NCTX; k++) begin
      if (rd_idx == CW'(k)) begin
        rd_rx_desc = rxd_all[k];
        rd_rx_done = rxs_all[k];
        rd_tx_desc = txd_all[k];
        rd_tx_done = txs_all[k];
      end
    end
  end
endmodule

// File: rtl/vctx_req_fifo.sv
module vctx_req_fifo #(
  parameter int DEPTH = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_idx,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_idx,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [CW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          pop;

  assign pop       = out_valid && out_ready;
  assign out_valid = cnt != '0;
  assign empty     = cnt == '0;
  assign full      = cnt == NW'(DEPTH);
  assign out_idx   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= push_idx;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/vctx_status_merge.sv
module vctx_status_merge
  import vctx_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [DW-1:0]    rx_done,
  input  logic [PKT_W-1:0] rx_pkts,
  input  logic [DW-1:0]    tx_done,
  input  logic [PKT_W-1:0] tx_pkts,
  input  logic [LW-1:0]    tx_free,
  input  logic [LW-1:0]    tx_used,
  input  logic [LW-1:0]    tx_max_copy,
  input  logic [LW-1:0]    tx_mark,
  output logic [DW-1:0]    rx_view,
  output logic [DW-1:0]    tx_view
);
  always_comb begin
    rx_view = rx_done;
    rx_view[PKT_LSB +: PKT_W] = rx_pkts;

    tx_view = tx_done;
    tx_view[PKT_LSB +: PKT_W] = tx_pkts;
    tx_view[FULL_BIT] = tx_free < tx_max_copy;
    tx_view[LOW_BIT]  = tx_used < tx_mark;
  end
endmodule

// File: rtl/vctx_reg_front.sv
module vctx_reg_front
  import vctx_pkg::*;
#(
  parameter int  NCTX = 4,
  parameter int  AW   = 16,
  parameter int  LW   = 16,
  localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [AW-1:0]    acc_addr,
  input  logic [63:0]      acc_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [63:0]      rsp_rdata,
  input  logic             rx_en,
  input  logic             rx_idle,
  input  logic             tx_en,
  input  logic             tx_idle,
  output logic             rx_kick,
  output logic             tx_kick,
  input  logic             rx_cmpl_valid,
  input  logic [CW-1:0]    rx_cmpl_ctx,
  input  logic [63:0]      rx_cmpl_word,
  input  logic             tx_cmpl_valid,
  input  logic [CW-1:0]    tx_cmpl_ctx,
  input  logic [63:0]      tx_cmpl_word,
  input  logic [15:0]      rx_fifo_pkts,
  input  logic [15:0]      tx_fifo_pkts,
  input  logic [LW-1:0]    tx_fifo_free,
  input  logic [LW-1:0]    tx_fifo_used,
  input  logic [LW-1:0]    tx_max_copy,
  input  logic [LW-1:0]    tx_mark,
  output logic             rxq_valid,
  input  logic             rxq_ready,
  output logic [CW-1:0]    rxq_ctx,
  output logic             rxq_full,
  output logic             rxq_empty,
  output logic             txq_valid,
  input  logic             txq_ready,
  output logic [CW-1:0]    txq_ctx,
  output logic             txq_full,
  output logic             txq_empty
);
  logic [CW-1:0] ctx_idx;
  logic          idx_ok;
  reg_kind_e     kind;

  logic [DW-1:0] cur_rx_desc, cur_rx_done, cur_tx_desc, cur_tx_done;
  logic [DW-1:0] rx_view, tx_view;

  logic rx_busy_sel, tx_busy_sel;
  logic is_rxd_wr, is_txd_wr, is_stat_wr;
  logic rx_accept, tx_accept, rx_push, tx_push, tx_head_match;
  logic acc_bad;
  logic [DW-1:0] rd_mux;

  vctx_addr_dec #(.AW(AW), .NCTX(NCTX), .CW(CW)) u_dec (
    .addr    (acc_addr),
    .ctx_idx (ctx_idx),
    .idx_ok  (idx_ok),
    .kind    (kind)
  );

  assign rx_busy_sel = cur_rx_done[BUSY_BIT];
  assign tx_busy_sel = cur_tx_done[BUSY_BIT];

  assign is_rxd_wr  = acc_en && acc_wr && idx_ok && (kind == KIND_RX_DESC);
  assign is_txd_wr  = acc_en && acc_wr && idx_ok && (kind == KIND_TX_DESC);
  assign is_stat_wr = acc_wr && ((kind == KIND_RX_STAT) || (kind == KIND_TX_STAT));

  // a transmit head that is leaving this cycle does not absorb a new request
  assign tx_head_match = txq_valid && !txq_ready && (txq_ctx == ctx_idx);

  assign rx_accept = is_rxd_wr && !rx_busy_sel && !rxq_full;
  assign rx_push   = rx_accept;
  assign tx_accept = is_txd_wr && !tx_busy_sel && (!txq_full || tx_head_match);
  assign tx_push   = tx_accept && !tx_head_match;

  assign acc_bad = acc_en && (!idx_ok || (kind == KIND_NONE) || is_stat_wr ||
                              (is_rxd_wr && !rx_accept) ||
                              (is_txd_wr && !tx_accept));

  vctx_ctx_bank #(.NCTX(NCTX), .CW(CW)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxd_we        (rx_accept),
    .txd_we        (tx_accept),
    .wr_idx        (ctx_idx),
    .wdata         (acc_wdata),
    .rx_cmpl_valid (rx_cmpl_valid),
    .rx_cmpl_idx   (rx_cmpl_ctx),
    .rx_cmpl_word  (rx_cmpl_word),
    .tx_cmpl_valid (tx_cmpl_valid),
    .tx_cmpl_idx   (tx_cmpl_ctx),
    .tx_cmpl_word  (tx_cmpl_word),
    .rd_idx        (ctx_idx),
    .rd_rx_desc    (cur_rx_desc),
    .rd_rx_done    (cur_rx_done),
    .rd_tx_desc    (cur_tx_desc),
    .rd_tx_done    (cur_tx_done)
  );

  vctx_status_merge #(.LW(LW)) u_merge (
    .rx_done     (cur_rx_done),
    .rx_pkts     (rx_fifo_pkts),
    .tx_done     (cur_tx_done),
    .tx_pkts     (tx_fifo_pkts),
    .tx_free     (tx_fifo_free),
    .tx_used     (tx_fifo_used),
    .tx_max_copy (tx_max_copy),
    .tx_mark     (tx_mark),
    .rx_view     (rx_view),
    .tx_view     (tx_view)
  );

  vctx_req_fifo #(.DEPTH(NCTX), .CW(CW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_idx  (ctx_idx),
    .out_valid (rxq_valid),
    .out_ready (rxq_ready),
    .out_idx   (rxq_ctx),
    .full      (rxq_full),
    .empty     (rxq_empty)
  );

  vctx_req_fifo #(.DEPTH(NCTX), .CW(CW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_idx  (ctx_idx),
    .out_valid (txq_valid),
    .out_ready (txq_ready),
    .out_idx   (txq_ctx),
    .full      (txq_full),
    .empty     (txq_empty)
  );

  always_comb begin
    case (kind)
      KIND_RX_DESC: rd_mux = cur_rx_desc;
      KIND_RX_STAT: rd_mux = rx_view;
      KIND_TX_DESC: rd_mux = cur_tx_desc;
      KIND_TX_STAT: rd_mux = tx_view;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      rx_kick   <= 1'b0;
      tx_kick   <= 1'b0;
    end else begin
      rsp_valid <= acc_en;
      rsp_err   <= acc_bad;
      rsp_rdata <= (acc_en && !acc_wr && !acc_bad) ? rd_mux : '0;
      rx_kick   <= rx_accept && rx_en && rx_idle;
      tx_kick   <= tx_accept && tx_en && tx_idle;
    end
  end
endmodule

// File: rtl/vctx_reg_front_chk.sv
module vctx_reg_front_chk
  import vctx_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int AW   = 16,
  parameter int LW   = 16,
  parameter int CW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [AW-1:0] acc_addr,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [63:0]   rsp_rdata,
  input logic          rx_kick,
  input logic          tx_kick,
  input logic          rxq_valid,
  input logic          rxq_ready,
  input logic [CW-1:0] rxq_ctx,
  input logic          rxq_empty,
  input logic          txq_valid,
  input logic          txq_ready,
  input logic [CW-1:0] txq_ctx,
  input logic          txq_empty,
  input logic [LW-1:0] tx_fifo_free,
  input logic [LW-1:0] tx_max_copy,
  input logic          rx_busy_sel
);
  logic          in_range;
  logic [7:0]    ofs;
  assign in_range = acc_addr[AW-1:8] < (AW-8)'(NCTX);
  assign ofs      = acc_addr[7:0];

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !in_range) |=> (rsp_valid && rsp_err));

  // R3
  rx_busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && in_range && ofs == OFS_RX_DESC && rx_busy_sel) |=> rsp_err);

  // R4
  kick_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_kick || tx_kick) |-> (rsp_valid && !rsp_err));

  // R7
  tx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && in_range && (ofs == OFS_TX_STAT || ofs == OFS_TX_POLL) &&
     (tx_fifo_free < tx_max_copy)) |=> rsp_rdata[FULL_BIT]);

  // R9
  rxq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_valid && !rxq_ready) |=> (rxq_valid && $stable(rxq_ctx)));

  // R9
  txq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_valid && !txq_ready) |=> (txq_valid && $stable(txq_ctx)));

  // R9
  q_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_empty != rxq_valid) && (txq_empty != txq_valid));
endmodule

bind vctx_reg_front vctx_reg_front_chk #(.NCTX(NCTX), .AW(AW), .LW(LW), .CW(CW)) u_chk (.*);

// File: tb/test_vctx_reg_front.sv
module test_vctx_reg_front;
  localparam int NCTX = 4;
  localparam int AW   = 16;
  localparam int LW   = 16;
  localparam int CW   = 2;
  localparam logic [63:0] BUSY = 64'h0000_0000_8000_0000;

  logic clk = 0;
  logic rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [63:0] acc_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic rx_en = 0, rx_idle = 0, tx_en = 0, tx_idle = 0;
  logic rx_kick, tx_kick;
  logic rx_cmpl_valid = 0, tx_cmpl_valid = 0;
  logic [CW-1:0] rx_cmpl_ctx = '0, tx_cmpl_ctx = '0;
  logic [63:0] rx_cmpl_word = '0, tx_cmpl_word = '0;
  logic [15:0] rx_fifo_pkts = '0, tx_fifo_pkts = '0;
  logic [LW-1:0] tx_fifo_free = '0, tx_fifo_used = '0, tx_max_copy = '0, tx_mark = '0;
  logic rxq_valid, rxq_full, rxq_empty, txq_valid, txq_full, txq_empty;
  logic rxq_ready = 0, txq_ready = 0;
  logic [CW-1:0] rxq_ctx, txq_ctx;

  int total = 0;
  int bad = 0;

  logic [63:0] q_d[$];
  bit          q_e[$], q_rk[$], q_tk[$];
  string       q_tag[$];

  vctx_reg_front #(.NCTX(NCTX), .AW(AW), .LW(LW)) i_vctx_reg_front (.*);

  always #5 clk = ~clk;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_d.size() == 0) begin
        check(64'd1, 64'd0, "unexpected response");
      end else begin
        string t;
        t = q_tag.pop_front();
        check(rsp_rdata, q_d.pop_front(), t);
        check(64'(rsp_err), 64'(q_e.pop_front()), {t, " err"});
        check(64'(rx_kick), 64'(q_rk.pop_front()), {t, " rx_kick"});
        check(64'(tx_kick), 64'(q_tk.pop_front()), {t, " tx_kick"});
      end
    end
  end

  task automatic access(input bit wr, input int ctx, input logic [7:0] ofs,
                        input logic [63:0] wd, input logic [63:0] exp_d,
                        input bit exp_e, input bit exp_rk, input bit exp_tk,
                        input string tag);
    @(negedge clk);
    acc_en    = 1;
    acc_wr    = wr;
    acc_addr  = AW'(ctx) << 8 | AW'(ofs);
    acc_wdata = wd;
    q_d.push_back(exp_d); q_e.push_back(exp_e);
    q_rk.push_back(exp_rk); q_tk.push_back(exp_tk); q_tag.push_back(tag);
    @(negedge clk);
    acc_en = 0;
  endtask

  task automatic rx_done_pulse(input int ctx, input logic [63:0] w);
    @(negedge clk);
    rx_cmpl_valid = 1; rx_cmpl_ctx = CW'(ctx); rx_cmpl_word = w;
    @(negedge clk);
    rx_cmpl_valid = 0;
  endtask

  task automatic tx_done_pulse(input int ctx, input logic [63:0] w);
    @(negedge clk);
    tx_cmpl_valid = 1; tx_cmpl_ctx = CW'(ctx); tx_cmpl_word = w;
    @(negedge clk);
    tx_cmpl_valid = 0;
  endtask

  task automatic pop_rx(input int exp, input string tag);
    @(negedge clk);
    check(64'(rxq_valid), 64'd1, {tag, " rxq_valid"});
    check(64'(rxq_ctx), 64'(exp), {tag, " rxq_ctx"});
    @(negedge clk);
    check(64'(rxq_ctx), 64'(exp), {tag, " rxq_ctx held"});
    rxq_ready = 1;
    @(negedge clk);
    rxq_ready = 0;
  endtask

  task automatic pop_tx(input int exp, input string tag);
    @(negedge clk);
    check(64'(txq_valid), 64'd1, {tag, " txq_valid"});
    check(64'(txq_ctx), 64'(exp), {tag, " txq_ctx"});
    @(negedge clk);
    txq_ready = 1;
    @(negedge clk);
    txq_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(64'(rxq_empty), 64'd1, "R10 rxq_empty");
    check(64'(txq_empty), 64'd1, "R10 txq_empty");
    check(64'(rxq_valid), 64'd0, "R10 rxq_valid");
    check(64'(rsp_valid), 64'd0, "R10 rsp_valid");
    access(0, 2, 8'h08, 0, 64'd0, 0, 0, 0, "R10 status after reset");

    // R2 accepted receive descriptor, R4 kick when idle and enabled
    rx_en = 1; rx_idle = 1;
    access(1, 1, 8'h00, 64'h1234_5678_9ABC_DEF0, 0, 0, 1, 0, "R2 R4 rx write kick");
    rx_fifo_pkts = 16'd5;
    access(0, 1, 8'h08, 0, BUSY | (64'd5 << 32), 0, 0, 0, "R6 rx status");
    access(0, 1, 8'h10, 0, BUSY | (64'd5 << 32), 0, 0, 0, "R6 rx mirror");
    access(0, 1, 8'h00, 0, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, "R11 rx desc read");

    // R3 busy context rejected
    access(1, 1, 8'h00, 64'hFFFF, 0, 1, 0, 0, "R3 busy write");
    access(0, 1, 8'h00, 0, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, "R3 desc unchanged");

    // R4 no kick when engine busy
    rx_idle = 0;
    access(1, 3, 8'h00, 64'h33, 0, 0, 0, 0, "R4 rx no kick");
    check(64'(rxq_full), 64'd0, "R9 rxq not full");
    pop_rx(1, "R9 rx order first");
    pop_rx(3, "R9 rx order second");
    @(negedge clk);
    check(64'(rxq_empty), 64'd1, "R9 rxq drained");

    // R8 completion clears busy
    rx_done_pulse(1, 64'h0000_0000_C000_0040);
    rx_fifo_pkts = 16'd2;
    access(0, 1, 8'h08, 0, 64'h0000_0002_4000_0040, 0, 0, 0, "R8 rx completion word");
    access(1, 1, 8'h00, 64'h77, 0, 0, 0, 0, "R8 rx rewrite accepted");

    // R5 and R7 transmit path
    tx_en = 1; tx_idle = 1;
    access(1, 2, 8'h18, 64'hAA, 0, 0, 0, 1, "R5 R4 tx write kick");
    tx_fifo_pkts = 16'd7; tx_fifo_free = 10; tx_max_copy = 16; tx_fifo_used = 3; tx_mark = 2;
    access(0, 2, 8'h20, 0, BUSY | (64'd1 << 29) | (64'd7 << 32), 0, 0, 0, "R7 tx full flag");
    tx_fifo_free = 20; tx_fifo_used = 1;
    access(0, 2, 8'h28, 0, BUSY | (64'd1 << 28) | (64'd7 << 32), 0, 0, 0, "R7 tx low flag mirror");
    access(0, 2, 8'h18, 0, 64'hAA, 0, 0, 0, "R11 tx desc read");

    // R5 head dedup
    tx_idle = 0;
    tx_done_pulse(2, 64'h0000_0000_4000_0010);
    access(1, 2, 8'h18, 64'hBB, 0, 0, 0, 0, "R5 tx same head accepted");
    access(1, 0, 8'h18, 64'hCC, 0, 0, 0, 0, "R5 tx other ctx");
    pop_tx(2, "R5 tx head");
    pop_tx(0, "R5 tx second");
    @(negedge clk);
    check(64'(txq_empty), 64'd1, "R5 no duplicate entry");

    // R1 index range, R11 bad offsets
    access(1, 4, 8'h00, 64'h99, 0, 1, 0, 0, "R1 index beyond range write");
    access(0, 5, 8'h08, 0, 0, 1, 0, 0, "R1 index beyond range read");
    access(0, 0, 8'h30, 0, 0, 1, 0, 0, "R11 unknown offset");
    access(1, 0, 8'h08, 64'h5, 0, 1, 0, 0, "R11 status write");
    rx_fifo_pkts = 0;
    access(0, 0, 8'h08, 0, 0, 0, 0, 0, "R1 R11 ctx0 untouched");

    // R9 queue full
    rx_done_pulse(3, 64'h0000_0000_4000_0003);
    access(1, 0, 8'h00, 64'h10, 0, 0, 0, 0, "R9 fill ctx0");
    access(1, 2, 8'h00, 64'h12, 0, 0, 0, 0, "R9 fill ctx2");
    access(1, 3, 8'h00, 64'h13, 0, 0, 0, 0, "R9 fill ctx3");
    check(64'(rxq_full), 64'd1, "R9 rxq_full");
    rx_done_pulse(0, 64'h0000_0000_4000_0020);
    access(1, 0, 8'h00, 64'hEE, 0, 1, 0, 0, "R9 push to full rejected");
    access(0, 0, 8'h08, 0, 64'h0000_0000_4000_0020, 0, 0, 0, "R9 status unchanged");
    access(0, 0, 8'h00, 0, 64'h10, 0, 0, 0, "R9 desc unchanged");
    pop_rx(1, "R9 full order 1");
    pop_rx(0, "R9 full order 2");
    pop_rx(2, "R9 full order 3");
    pop_rx(3, "R9 full order 4");
    @(negedge clk);
    check(64'(rxq_empty), 64'd1, "R9 empty after drain");
    check(64'(q_d.size()), 64'd0, "all responses seen");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule